// File: doc/BRIEF.md
# Private Interrupt Pending Latch with Software-Interrupt Acceptance

This block holds the pending latches for the 32 interrupts private to one processor. Numbers 0 to 15 are software-generated interrupts. Numbers 16 to 31 are peripheral interrupts, and each has an input line. A peripheral line can be set up as edge-triggered or level-triggered. The block keeps the last sampled level of every line. A rising edge on an edge-triggered line latches the pending bit of its interrupt.

Software-interrupt requests come from other processors on a valid-qualified port, at most one per cycle. Each request carries three things:
- a requested group
- an interrupt number
- a non-secure flag

Before it sets a pending bit, the block runs three checks on the request:
- The requested group is compared with the configured group of the target interrupt.
- A security-disable flag is taken into account.
- The request is checked against a two-bit access field that belongs to the target interrupt.

A request that fails any check is dropped without a trace. Group configuration, the edge bitmap, the access word and the clear vector are all inputs. Register decoding and priority arbitration sit elsewhere.

Top module: `pip_pend_ctrl`

## Requirements
- R1: After reset, every pending bit and every stored line level is 0.
- R2: The stored level of each peripheral line (`lvl_o` bit k for interrupt 16+k) equals the line value sampled at the previous clock edge. A line that keeps its stored value changes no pending bit.
- R3: When an edge-configured line (`ppi_edge_i` bit k = 1) goes from a stored 0 to a sampled 1, `pend_o` bit 16+k is set at that clock edge.
- R4: A level-configured line (`ppi_edge_i` bit k = 0) never sets a pending bit. Only its stored level changes.
- R5: Group codes are 0 = group 0, 1 = secure group 1, 2 = non-secure group 1 and 3 = reserved. The configured group of interrupt n is bits 2n+1:2n of `sgi_grp_cfg_i`. A request whose group equals a non-reserved configured group passes the group check.
- R6: A secure-group-1 request that targets a group-0 interrupt passes the group check, and it is treated as group 0 from then on.
- R7: Every other group combination drops the request. This includes any target configured with the reserved code.
- R8: The access field of interrupt n is bits 2n+1:2n of `sgi_acc_i`. A non-secure request with security enabled needs the following access field, depending on its effective group:
  - group 0: a field of at least 1
  - secure group 1: a field of at least 2
  - non-secure group 1: no access check
- R9: When `sec_dis_i` is 1, the access check is skipped.
- R10: A request that passes its checks while `req_valid_i` is 1 sets `pend_o` bit `req_num_i` at that clock edge. Nothing is set while `req_valid_i` is 0.
- R11: A 1 in `pend_clr_i` clears that pending bit at the clock edge. A set of the same bit in the same cycle takes priority over the clear.
- R12: A pending bit that is neither set nor cleared keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ppi_lvl_i | input | 16 | Peripheral line levels; bit k is interrupt 16+k |
| ppi_edge_i | input | 16 | 1 = line k is edge-triggered |
| sgi_grp_cfg_i | input | 32 | Two-bit configured group per software interrupt |
| sgi_acc_i | input | 32 | Two-bit non-secure access field per software interrupt |
| sec_dis_i | input | 1 | 1 = security disabled |
| req_valid_i | input | 1 | A software-interrupt request is present |
| req_num_i | input | 4 | Target software-interrupt number |
| req_grp_i | input | 2 | Requested group code |
| req_ns_i | input | 1 | 1 = the request is non-secure |
| pend_clr_i | input | 32 | Per-interrupt pending clear |
| pend_o | output | 32 | Pending latches |
| lvl_o | output | 16 | Stored peripheral line levels |

## Verification
Some properties are checked by assertions on every cycle:
- Pending bits hold unless they are cleared.
- A new pending bit always traces back to a set cause from the previous cycle.
- The stored levels track the sampled lines.
- Every accepted request meets both the group rule and the access-field rule.

The bench scenarios cover what the assertions cannot. These include the exact decisions for each combination of group, access field, security flag and non-secure flag, the remapping of secure group 1 onto group 0, the set-over-clear priority, and the rule that level-triggered lines never latch. All of these are compared against a bench reference model, in directed corner cases and in a long random run.

// File: rtl/pip_pkg.sv
package pip_pkg;
  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_RSVD = 2'd3
  } grp_e;
endpackage

// File: rtl/pip_sgi_filter.sv
module pip_sgi_filter
  import pip_pkg::*;
#(
  parameter int NUM_SGI = 16,
  localparam int SGI_W  = $clog2(NUM_SGI)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [SGI_W-1:0]     num_i,
  input  logic [1:0]           grp_i,
  input  logic                 ns_i,
  input  logic                 sec_dis_i,
  input  logic [2*NUM_SGI-1:0] grp_cfg_i,
  input  logic [2*NUM_SGI-1:0] acc_i,
  output logic [NUM_SGI-1:0]   set_o
);
  grp_e       cfg, req, eff;
  logic [1:0] acc;
  logic       grp_ok, acc_ok, accept;

  always_comb begin
    cfg    = grp_e'(grp_cfg_i[num_i*2 +: 2]);
    req    = grp_e'(grp_i);
    acc    = acc_i[num_i*2 +: 2];
    grp_ok = (cfg != GRP_RSVD) && ((req == cfg) || (req == GRP_G1S && cfg == GRP_G0));
    eff    = (req == cfg) ? cfg : GRP_G0;  // secure G1 on a G0 target acts as G0
    acc_ok = !ns_i || sec_dis_i || (eff == GRP_G1NS)
           || (eff == GRP_G0  && acc >= 2'd1)
           || (eff == GRP_G1S && acc >= 2'd2);
    accept = valid_i && grp_ok && acc_ok;
  end

  for (genvar n = 0; n < NUM_SGI; n++) begin : g_set
    assign set_o[n] = accept && (num_i == SGI_W'(n));
  end

  // Any accepted request satisfies the group rule
  assert_grp_rule_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_o) |-> (grp_cfg_i[num_i*2 +: 2] != 2'd3) &&
                 ((grp_i == grp_cfg_i[num_i*2 +: 2]) ||
                  (grp_i == 2'd1 && grp_cfg_i[num_i*2 +: 2] == 2'd0)));

  // Non-secure, security-enabled acceptance needs enough access
  assert_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|set_o) && ns_i && !sec_dis_i && grp_cfg_i[num_i*2 +: 2] != 2'd2)
      |-> (acc_i[num_i*2 +: 2] >= ((grp_i == 2'd1 && grp_cfg_i[num_i*2 +: 2] == 2'd1) ? 2'd2 : 2'd1)));

  assert_valid_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (set_o == '0));
endmodule

// File: rtl/pip_ppi_track.sv
module pip_ppi_track #(
  parameter int NUM_PPI = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PPI-1:0] lvl_i,
  input  logic [NUM_PPI-1:0] edge_i,
  output logic [NUM_PPI-1:0] lvl_o,
  output logic [NUM_PPI-1:0] set_o
);
  for (genvar k = 0; k < NUM_PPI; k++) begin : g_line
    logic lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= 1'b0;
      else         lvl_q <= lvl_i[k];
    end
    assign lvl_o[k] = lvl_q;
    assign set_o[k] = edge_i[k] && lvl_i[k] && !lvl_q;
  end

  assert_level_track_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (lvl_o == $past(lvl_i)));

  assert_level_no_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o & ~edge_i) == '0);
endmodule

// File: rtl/pip_pend_ctrl.sv
module pip_pend_ctrl #(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
  localparam int SGI_W   = $clog2(NUM_SGI)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PPI-1:0]   ppi_lvl_i,
  input  logic [NUM_PPI-1:0]   ppi_edge_i,
  input  logic [2*NUM_SGI-1:0] sgi_grp_cfg_i,
  input  logic [2*NUM_SGI-1:0] sgi_acc_i,
  input  logic                 sec_dis_i,
  input  logic                 req_valid_i,
  input  logic [SGI_W-1:0]     req_num_i,
  input  logic [1:0]           req_grp_i,
  input  logic                 req_ns_i,
  input  logic [NUM_IRQ-1:0]   pend_clr_i,
  output logic [NUM_IRQ-1:0]   pend_o,
  output logic [NUM_PPI-1:0]   lvl_o
);
  logic [NUM_SGI-1:0] sgi_set;
  logic [NUM_PPI-1:0] ppi_set;
  logic [NUM_IRQ-1:0] set_vec, pend_q;

  pip_sgi_filter #(.NUM_SGI(NUM_SGI)) u_filter (
    .clk_i, .rst_ni,
    .valid_i   (req_valid_i),
    .num_i     (req_num_i),
    .grp_i     (req_grp_i),
    .ns_i      (req_ns_i),
    .sec_dis_i (sec_dis_i),
    .grp_cfg_i (sgi_grp_cfg_i),
    .acc_i     (sgi_acc_i),
    .set_o     (sgi_set)
  );

  pip_ppi_track #(.NUM_PPI(NUM_PPI)) u_ppi (
    .clk_i, .rst_ni,
    .lvl_i  (ppi_lvl_i),
    .edge_i (ppi_edge_i),
    .lvl_o  (lvl_o),
    .set_o  (ppi_set)
  );

  assign set_vec = {ppi_set, sgi_set};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~pend_clr_i) | set_vec;  // set beats clear
  end

  assign pend_o = pend_q;

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend_q) & ~$past(pend_clr_i)) & ~pend_q) == '0);

  assert_set_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q)) & ~$past(set_vec)) == '0);

  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(set_vec) & ~pend_q) == '0);
endmodule

// File: tb/pip_pend_ctrl_tb_top.sv
`timescale 1ns/1ps
module pip_pend_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ppi_lvl_i = '0, ppi_edge_i = '0;
  logic [31:0] sgi_grp_cfg_i = '0, sgi_acc_i = '0, pend_clr_i = '0;
  logic        sec_dis_i = 1'b0, req_valid_i = 1'b0, req_ns_i = 1'b0;
  logic [3:0]  req_num_i = '0;
  logic [1:0]  req_grp_i = '0;
  logic [31:0] pend_o;
  logic [15:0] lvl_o;

  logic [31:0] exp_pend = '0;
  logic [15:0] exp_lvl = '0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  pip_pend_ctrl dut_i (.*);

  function automatic bit sgi_ok(logic [1:0] cfg, logic [1:0] req, logic ns,
                                logic dis, logic [1:0] acc);
    logic [1:0] eff;
    if (cfg == 2'd3) return 0;
    if (req == cfg) eff = cfg;
    else if (req == 2'd1 && cfg == 2'd0) eff = 2'd0;
    else return 0;
    if (ns && !dis) begin
      if (eff == 2'd0 && acc < 2'd1) return 0;
      if (eff == 2'd1 && acc < 2'd2) return 0;
    end
    return 1;
  endfunction

  task automatic tick();
    logic [31:0] s = '0;
    for (int k = 0; k < 16; k++)
      if (ppi_edge_i[k] && ppi_lvl_i[k] && !exp_lvl[k]) s[16+k] = 1'b1;
    if (req_valid_i && sgi_ok(sgi_grp_cfg_i[req_num_i*2 +: 2], req_grp_i, req_ns_i,
                              sec_dis_i, sgi_acc_i[req_num_i*2 +: 2]))
      s[req_num_i] = 1'b1;
    exp_pend = (exp_pend & ~pend_clr_i) | s;
    exp_lvl  = ppi_lvl_i;
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, pend_o, exp_pend);
    chk(tag, {16'h0, lvl_o}, {16'h0, exp_lvl});
  endtask

  task automatic req(int num, logic [1:0] grp, logic ns);
    req_valid_i = 1; req_num_i = 4'(num); req_grp_i = grp; req_ns_i = ns;
    tick();
    req_valid_i = 0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    chk("R1 reset pend", pend_o, 32'h0);
    chk("R1 reset lvl", {16'h0, lvl_o}, 32'h0);

    ppi_lvl_i[3] = 1; tick();                       // level-triggered line
    chk("R4 lvl", {16'h0, lvl_o}, 32'h0008);
    chk("R4 no pend", pend_o, 32'h0);
    tick(); chk_all("R2 unchanged");
    ppi_edge_i[5] = 1; ppi_lvl_i[5] = 1; tick();
    chk("R3 edge set", pend_o, 32'h0020_0000);
    pend_clr_i = 32'h0020_0000; tick(); pend_clr_i = '0;
    chk("R11 clear", pend_o, 32'h0);
    tick(); chk("R2 held high no re-set", pend_o, 32'h0);

    req(4, 2'd1, 0);  chk("R6 G1S on G0", pend_o, 32'h0000_0010);
    req(5, 2'd2, 0);  chk("R7 G1NS on G0 drop", pend_o, 32'h0000_0010);
    sgi_grp_cfg_i[13:12] = 2'd3;
    req(6, 2'd3, 0);  chk("R7 reserved drop", pend_o, 32'h0000_0010);
    req(7, 2'd0, 1);  chk("R8 G0 acc0 drop", pend_o, 32'h0000_0010);
    sgi_acc_i[15:14] = 2'd1;
    req(7, 2'd0, 1);  chk("R8 G0 acc1 ok", pend_o, 32'h0000_0090);
    sgi_grp_cfg_i[17:16] = 2'd1; sgi_acc_i[17:16] = 2'd1;
    req(8, 2'd1, 1);  chk("R8 G1S acc1 drop", pend_o, 32'h0000_0090);
    sgi_acc_i[17:16] = 2'd2;
    req(8, 2'd1, 1);  chk("R8 G1S acc2 ok", pend_o, 32'h0000_0190);
    sgi_grp_cfg_i[19:18] = 2'd2;
    req(9, 2'd2, 1);  chk("R8 G1NS no check", pend_o, 32'h0000_0390);
    sec_dis_i = 1;
    req(10, 2'd0, 1); chk("R9 sec disabled", pend_o, 32'h0000_0790);
    sec_dis_i = 0;
    req_num_i = 4'd11; req_grp_i = 2'd0; req_ns_i = 0; tick();
    chk("R10 no valid", pend_o, 32'h0000_0790);
    pend_clr_i = 32'h10; req(4, 2'd0, 0); pend_clr_i = '0;
    chk("R11 set wins", pend_o, 32'h0000_0790);
    sgi_grp_cfg_i[25:24] = 2'd1;
    req(12, 2'd1, 0); chk("R5 equal group", pend_o, 32'h0000_1790);
    chk_all("R10 model agree");

    for (int i = 0; i < 3000; i++) begin
      ppi_lvl_i     = 16'($urandom);
      ppi_edge_i    = 16'($urandom);
      sgi_grp_cfg_i = $urandom;
      sgi_acc_i     = $urandom;
      sec_dis_i     = ($urandom % 4) == 0;
      req_valid_i   = $urandom % 2;
      req_num_i     = 4'($urandom);
      req_grp_i     = 2'($urandom);
      req_ns_i      = $urandom % 2;
      pend_clr_i    = $urandom & $urandom & $urandom;
      tick();
      chk_all("R12 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule